// File: doc/BRIEF.md
# Two-Product Coin Vending Controller

This block is the decision core of a small vending machine that sells candy and soda and takes nickels and dimes. Each clock cycle it looks at four single-cycle event strobes: a nickel was inserted, a dime was inserted, the candy button was pressed, or the soda button was pressed. It keeps the customer's credit in 5-cent steps. The credit saturates at 15 cents, so the credit levels are 0, 5, 10 and 15. The present credit is shown on a 4-bit unsigned output in cents.

A purchase strobe fires in the same cycle as the button press when the credit covers the price. Candy costs 10 cents and soda costs 15 cents. Because these strobes depend on both the stored credit and the current button, they are Mealy outputs. This lets the machine use only the four credit levels as its state. The price is then taken from the credit at the next clock edge. Normal use allows at most one event per cycle. A cycle that carries more than one event is treated as corrupt and is dropped.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst` is high, `vend_candy` and `vend_soda` are low whatever the inputs are, and after the first clock edge with `rst` high `credit` reads 0.
- R2: A nickel alone (`coin_nickel` high, the other three inputs low) raises `credit` by 5 at the next clock edge, and holds it at 15 if the sum would exceed 15.
- R3: A dime alone raises `credit` by 10 at the next clock edge, and holds it at 15 if the sum would exceed 15.
- R4: A candy press alone with `credit` of at least 10 drives `vend_candy` high in that same cycle, and lowers `credit` by 10 at the next edge.
- R5: A soda press alone with `credit` equal to 15 drives `vend_soda` high in that same cycle, and sets `credit` to 0 at the next edge.
- R6: A candy press with `credit` below 10, or a soda press with `credit` below 15, gives no dispense strobe and leaves `credit` unchanged.
- R7: A cycle with two or more of the four inputs high is ignored: both dispense strobes stay low and `credit` is unchanged.
- R8: A cycle with none of the inputs high leaves `credit` unchanged and gives no dispense strobe.
- R9: `vend_candy` and `vend_soda` are never high in the same cycle, and `credit` never exceeds 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coin_dime | input | 1 | A dime was inserted this cycle |
| coin_nickel | input | 1 | A nickel was inserted this cycle |
| req_candy | input | 1 | The candy button was pressed this cycle |
| req_soda | input | 1 | The soda button was pressed this cycle |
| vend_candy | output | 1 | Releases one candy (same-cycle strobe) |
| vend_soda | output | 1 | Releases one soda (same-cycle strobe) |
| credit | output | 4 | Current credit in cents: 0, 5, 10 or 15 |

## Verification
A table of single-event cycles takes the credit through every level. Nickel runs and dime runs reach the 15-cent ceiling and push against it, which shows the saturation separately from the plain addition. Candy and soda presses are made both at the levels that cover the price and at the levels that fall short, so the bench can tell a correct price threshold from one that is off by one step. Directed cycles then assert pairs of inputs at a known credit, including a coin together with a button, to show that such cycles are dropped. Reset is applied with a coin and a button held high, to show that reset wins over both.

// File: rtl/vend_pkg.sv
package vend_pkg;
  // Decoded meaning of one cycle's input strobes
  typedef enum logic [2:0] {
    EV_NONE   = 3'd0,
    EV_NICKEL = 3'd1,
    EV_DIME   = 3'd2,
    EV_CANDY  = 3'd3,
    EV_SODA   = 3'd4,
    EV_BAD    = 3'd5
  } vend_ev_t;
endpackage

// File: rtl/vend_evdec.sv
module vend_evdec
  import vend_pkg::*;
(
  input  logic     coin_dime,
  input  logic     coin_nickel,
  input  logic     req_candy,
  input  logic     req_soda,
  output vend_ev_t ev
);
  logic [3:0] strobes;
  assign strobes = {coin_dime, coin_nickel, req_candy, req_soda};

  always_comb begin
    ev = EV_NONE;
    if ($countones(strobes) > 1) ev = EV_BAD;
    else if (coin_dime)          ev = EV_DIME;
    else if (coin_nickel)        ev = EV_NICKEL;
    else if (req_candy)          ev = EV_CANDY;
    else if (req_soda)           ev = EV_SODA;
  end
endmodule

// File: rtl/vend_dispense.sv
module vend_dispense
  import vend_pkg::*;
#(
  parameter int LW       = 2,
  parameter int CANDY_LV = 2,
  parameter int SODA_LV  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  vend_ev_t      ev,
  input  logic [LW-1:0] lvl,
  output logic          grant_candy,
  output logic          grant_soda
);
  always_comb begin
    grant_candy = 1'b0;
    grant_soda  = 1'b0;
    if (!rst) begin
      if (ev == EV_CANDY && lvl >= LW'(CANDY_LV)) grant_candy = 1'b1;
      if (ev == EV_SODA  && lvl >= LW'(SODA_LV))  grant_soda  = 1'b1;
    end
  end

  AST_DISP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(grant_candy && grant_soda)); // R9
endmodule

// File: rtl/vend_ledger.sv
module vend_ledger
  import vend_pkg::*;
#(
  parameter int LW       = 2,
  parameter int MAX_LV   = 3,
  parameter int CANDY_LV = 2,
  parameter int SODA_LV  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  vend_ev_t      ev,
  input  logic          grant_candy,
  input  logic          grant_soda,
  output logic [LW-1:0] lvl
);
  logic [LW:0]   add_amt;
  logic [LW:0]   sum;
  logic [LW-1:0] lvl_nx;

  always_comb begin
    add_amt = '0;
    if (ev == EV_NICKEL) add_amt = (LW+1)'(1);
    if (ev == EV_DIME)   add_amt = (LW+1)'(2);
    sum = {1'b0, lvl} + add_amt;
    if (sum > (LW+1)'(MAX_LV)) lvl_nx = LW'(MAX_LV);
    else                       lvl_nx = sum[LW-1:0];
    if (grant_candy) lvl_nx = lvl - LW'(CANDY_LV);
    if (grant_soda)  lvl_nx = lvl - LW'(SODA_LV);
  end

  always_ff @(posedge clk) begin
    if (rst) lvl <= '0;
    else     lvl <= lvl_nx;
  end

  AST_LVL_CAP: assert property (@(posedge clk) disable iff (rst)
    lvl <= LW'(MAX_LV)); // R9
  AST_CANDY_DEBIT: assert property (@(posedge clk) disable iff (rst)
    grant_candy |=> lvl == $past(lvl) - LW'(CANDY_LV)); // R4
  AST_SODA_CLEAR: assert property (@(posedge clk) disable iff (rst)
    grant_soda |=> lvl == $past(lvl) - LW'(SODA_LV)); // R5
  AST_BAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_BAD) |=> lvl == $past(lvl)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_NONE) |=> lvl == $past(lvl)); // R8
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int CREDIT_W    = 4,
  parameter int STEP_CENTS  = 5,
  parameter int CAP_CENTS   = 15,
  parameter int CANDY_CENTS = 10,
  parameter int SODA_CENTS  = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                coin_dime,
  input  logic                coin_nickel,
  input  logic                req_candy,
  input  logic                req_soda,
  output logic                vend_candy,
  output logic                vend_soda,
  output logic [CREDIT_W-1:0] credit
);
  localparam int MAX_LV   = CAP_CENTS / STEP_CENTS;
  localparam int LW       = $clog2(MAX_LV + 1);
  localparam int CANDY_LV = CANDY_CENTS / STEP_CENTS;
  localparam int SODA_LV  = SODA_CENTS / STEP_CENTS;

  vend_ev_t      ev;
  logic [LW-1:0] lvl;
  logic          g_candy;
  logic          g_soda;

  vend_evdec u_dec (
    .coin_dime   (coin_dime),
    .coin_nickel (coin_nickel),
    .req_candy   (req_candy),
    .req_soda    (req_soda),
    .ev          (ev)
  );

  vend_dispense #(.LW(LW), .CANDY_LV(CANDY_LV), .SODA_LV(SODA_LV)) u_disp (
    .clk         (clk),
    .rst         (rst),
    .ev          (ev),
    .lvl         (lvl),
    .grant_candy (g_candy),
    .grant_soda  (g_soda)
  );

  vend_ledger #(.LW(LW), .MAX_LV(MAX_LV), .CANDY_LV(CANDY_LV), .SODA_LV(SODA_LV)) u_ledger (
    .clk         (clk),
    .rst         (rst),
    .ev          (ev),
    .grant_candy (g_candy),
    .grant_soda  (g_soda),
    .lvl         (lvl)
  );

  assign vend_candy = g_candy;
  assign vend_soda  = g_soda;
  assign credit     = CREDIT_W'(lvl) * CREDIT_W'(STEP_CENTS);
endmodule

// File: tb/tb_vend_ctrl.sv
module tb_vend_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  // row: [13:10] requirement, [9:6] credit after edge, [5] soda, [4] candy, [3:0] {dime,nickel,candy,soda}
  localparam logic [13:0] VEC [NV] = '{
    {4'd2, 4'd5,  1'b0, 1'b0, 4'b0100},  // R2 nickel 0->5
    {4'd2, 4'd10, 1'b0, 1'b0, 4'b0100},  // R2 5->10
    {4'd2, 4'd15, 1'b0, 1'b0, 4'b0100},  // R2 10->15
    {4'd2, 4'd15, 1'b0, 1'b0, 4'b0100},  // R2 saturate
    {4'd4, 4'd5,  1'b0, 1'b1, 4'b0010},  // R4 candy at 15
    {4'd6, 4'd5,  1'b0, 1'b0, 4'b0010},  // R6 candy at 5
    {4'd6, 4'd5,  1'b0, 1'b0, 4'b0001},  // R6 soda at 5
    {4'd3, 4'd15, 1'b0, 1'b0, 4'b1000},  // R3 dime 5->15
    {4'd5, 4'd0,  1'b1, 1'b0, 4'b0001},  // R5 soda at 15
    {4'd6, 4'd0,  1'b0, 1'b0, 4'b0010},  // R6 candy at 0
    {4'd3, 4'd10, 1'b0, 1'b0, 4'b1000},  // R3 dime 0->10
    {4'd6, 4'd10, 1'b0, 1'b0, 4'b0001},  // R6 soda at 10
    {4'd4, 4'd0,  1'b0, 1'b1, 4'b0010},  // R4 candy at 10
    {4'd8, 4'd0,  1'b0, 1'b0, 4'b0000},  // R8 idle
    {4'd3, 4'd10, 1'b0, 1'b0, 4'b1000},  // R3
    {4'd3, 4'd15, 1'b0, 1'b0, 4'b1000}   // R3 dime saturates 10->15
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coin_dime = 1'b0, coin_nickel = 1'b0, req_candy = 1'b0, req_soda = 1'b0;
  logic vend_candy, vend_soda;
  logic [3:0] credit;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vend_ctrl dut (
    .clk(clk), .rst(rst),
    .coin_dime(coin_dime), .coin_nickel(coin_nickel),
    .req_candy(req_candy), .req_soda(req_soda),
    .vend_candy(vend_candy), .vend_soda(vend_soda),
    .credit(credit)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, check strobes mid-cycle, check credit after the edge
  task automatic step(input logic [3:0] din, input string req,
                      input logic exp_c, input logic exp_s, input int exp_cr);
    @(negedge clk);
    {coin_dime, coin_nickel, req_candy, req_soda} = din;
    #1;
    check({req, " candy"}, int'(vend_candy), int'(exp_c));
    check({req, " soda"},  int'(vend_soda),  int'(exp_s));
    @(posedge clk);
    #1;
    check({req, " credit"}, int'(credit), exp_cr);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset with nickel and candy both held high
    @(negedge clk);
    {coin_dime, coin_nickel, req_candy, req_soda} = 4'b0110;
    #1;
    check("R1 candy in reset", int'(vend_candy), 0);
    check("R1 soda in reset", int'(vend_soda), 0);
    @(posedge clk); #1;
    check("R1 credit in reset", int'(credit), 0);
    @(negedge clk);
    {coin_dime, coin_nickel, req_candy, req_soda} = 4'b0000;
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", int'(VEC[i][13:10]), i);
      step(VEC[i][3:0], tag, VEC[i][4], VEC[i][5], int'(VEC[i][9:6]));
    end

    // R7: multi-input cycles at credit 15
    step(4'b0011, "R7 candy+soda", 1'b0, 1'b0, 15);
    step(4'b1100, "R7 dime+nickel", 1'b0, 1'b0, 15);
    step(4'b0110, "R7 nickel+candy", 1'b0, 1'b0, 15);
    step(4'b1111, "R7 all", 1'b0, 1'b0, 15);
    // R9: soda at full credit, strobes exclusive
    step(4'b0001, "R9 soda", 1'b0, 1'b1, 0);
    step(4'b1000, "R3 dime", 1'b0, 1'b0, 10);
    step(4'b0100, "R2 nickel", 1'b0, 1'b0, 15);

    // R1: reset mid-credit while candy pressed
    @(negedge clk);
    rst = 1'b1;
    {coin_dime, coin_nickel, req_candy, req_soda} = 4'b0010;
    #1;
    check("R1 candy gated by reset", int'(vend_candy), 0);
    @(posedge clk); #1;
    check("R1 credit cleared", int'(credit), 0);
    @(negedge clk);
    rst = 1'b0;
    {coin_dime, coin_nickel, req_candy, req_soda} = 4'b0000;
    step(4'b0010, "R6 candy after reset", 1'b0, 1'b0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule